// File: doc/BRIEF.md
# Multiplier-free quadratic word operator

This block computes y = X·(2X+1) mod 2^W on one W-bit word (W = 32 by default), which is the nonlinear mixing step of a 32-bit-word block cipher round. It builds no multiplier. Squaring identities fold the product into W/2 rows of AND terms: a diagonal product collapses to a single bit, and a symmetric pair becomes one term one column higher. The X addend fills the empty slots of the last row. Every term of weight 2^W or above is dropped, and the two bits that meet in the top column are combined by XOR, because their carry leaves the word. A chain of carry-propagate adders then sums the rows.

A parameter selects the timing. With PIPE = 0 the path is purely combinational and the valid flag passes straight through. With PIPE = 1 a result register loads on each valid input, and the valid flag is delayed one cycle to match it.

Top module: `rc6_quad_fn`

## Requirements
- R1: y equals (2·X² + X) mod 2^32 for the accepted X. For PIPE=0 this holds in the same cycle. For PIPE=1 it holds from the clock edge at which in_valid was high.
- R2: Bit 0 of the result always equals bit 0 of its operand.
- R3: Bit 1 of the result always equals bit 1 XOR bit 0 of its operand.
- R4: With PIPE=1, out_valid in a cycle equals in_valid sampled at the previous clock edge.
- R5: With PIPE=1, a clock edge with in_valid low leaves y unchanged, whatever x holds.
- R6: With PIPE=1, while rst_n is low, out_valid is 0 and y is 0.
- R7: With PIPE=0, out_valid equals in_valid and y follows x within the same cycle, with no clock edge.
- R8: Corner operands map as follows: 0 to 0, 1 to 3, 0xFFFFFFFF to 1, and 0x80000000 to 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only when PIPE=1) |
| rst_n | input | 1 | Active-low reset of the result register |
| in_valid | input | 1 | Operand qualifier |
| x | input | W | Operand word |
| out_valid | output | 1 | Result qualifier |
| y | output | W | Result word |

## Verification
A misplaced or missing AND term corrupts only those results whose operand bits activate that term. Random operands are therefore compared on every cycle, alongside the corner words, where single-column faults show at once. A wrong top-column combine shows as a bit-31 error on operands such as 0x80000000 or all-ones. A faulty result register or valid delay shows one cycle after an accepted or held operand, as a wrong qualifier or as a value that changed without in_valid.

// File: rtl/rc6_quad_fn.sv
module rc6_quad_fn #(
  parameter int W    = 32,
  parameter int PIPE = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] x,
  output logic         out_valid,
  output logic [W-1:0] y
);
  localparam int HALF = W / 2;
  localparam int ROWS = HALF;

  logic [W-1:0] row [ROWS];
  logic [W-1:0] acc [ROWS+1];
  logic [W-1:0] sum;

  // Rows 0..ROWS-2: diagonal x_r at 2r+1 and cross terms x_r&x_j at r+j+2.
  // Last row: X itself, with the top-column diagonal folded in by XOR.
  always_comb begin
    for (int r = 0; r < ROWS; r++) row[r] = '0;
    for (int r = 0; r < ROWS - 1; r++) begin
      row[r][2*r+1] = x[r];
      for (int j = r + 1; j < W - r - 2; j++)
        row[r][r+j+2] = x[r] & x[j];
    end
    row[ROWS-1] = {x[HALF-1] ^ x[W-1], x[W-2:0]};
  end

  assign acc[0] = '0;
  for (genvar k = 0; k < ROWS; k++) begin : g_cpa
    assign acc[k+1] = acc[k] + row[k];
  end
  assign sum = acc[ROWS];

  if (PIPE != 0) begin : g_reg
    logic [W-1:0] y_q;
    logic         v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        y_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= in_valid;
        if (in_valid) y_q <= sum;
      end
    end
    assign y = y_q;
    assign out_valid = v_q;

    a_r2_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> y[0] == $past(x[0]));
    a_r3_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> y[1] == ($past(x[1]) ^ $past(x[0])));
    a_r4_valid_up: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r4_valid_dn: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(y));
  end else begin : g_comb
    assign y = sum;
    assign out_valid = in_valid;

    a_r2_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      y[0] == x[0]);
    a_r3_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      y[1] == (x[1] ^ x[0]));
    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
    a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (x == '0) |-> (y == '0));
  end
endmodule

// File: tb/rc6_quad_fn_tb.sv
module rc6_quad_fn_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] x = '0;
  logic        ov_p, ov_c;
  logic [31:0] y_p, y_c;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] exp_y = '0;

  always #5 clk = ~clk;

  rc6_quad_fn #(.W(32), .PIPE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x),
    .out_valid(ov_p), .y(y_p));

  rc6_quad_fn #(.W(32), .PIPE(0)) u_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x),
    .out_valid(ov_c), .y(y_c));

  function automatic logic [31:0] ref_f(logic [31:0] v);
    longint unsigned a = 64'(v);
    return 32'(a * (2 * a + 1));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic step(logic v, logic [31:0] d, string tag);
    @(negedge clk);
    in_valid = v;
    x = d;
    #1;
    chk({tag, " R1 comb"}, y_c, ref_f(d));
    chk("R7 comb valid", 32'(ov_c), 32'(v));
    chk("R2 comb lsb", 32'(y_c[0]), 32'(d[0]));
    chk("R3 comb bit1", 32'(y_c[1]), 32'(d[1] ^ d[0]));
    @(posedge clk);
    if (v) exp_y = ref_f(d);
    #1;
    chk("R4 pipe valid", 32'(ov_p), 32'(v));
    if (v) chk({tag, " R1 pipe"}, y_p, exp_y);
    else   chk("R5 pipe hold", y_p, exp_y);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    x = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset valid", 32'(ov_p), 32'd0);
    chk("R6 reset y", y_p, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;

    step(1'b1, 32'h0000_0000, "R8 zero");
    chk("R8 zero", y_p, 32'h0000_0000);
    step(1'b1, 32'h0000_0001, "R8 one");
    chk("R8 one", y_p, 32'h0000_0003);
    step(1'b1, 32'hFFFF_FFFF, "R8 ones");
    chk("R8 ones", y_p, 32'h0000_0001);
    step(1'b1, 32'h8000_0000, "R8 msb");
    chk("R8 msb", y_p, 32'h8000_0000);
    step(1'b0, 32'hDEAD_BEEF, "R5 idle");
    step(1'b0, 32'h0000_0003, "R5 idle2");
    step(1'b1, 32'h0000_8000, "R1 mid");
    step(1'b1, 32'h0000_FFFF, "R1 lowhalf");
    step(1'b1, 32'hFFFF_0000, "R1 highhalf");
    step(1'b1, 32'hAAAA_AAAA, "R1 alt");
    step(1'b1, 32'h5555_5555, "R1 alt2");
    for (int i = 0; i < 32; i++) step(1'b1, 32'h1 << i, "R1 walk");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      logic        v = ($urandom % 4) != 0;
      step(v, r, "R1 rand");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule